// File: doc/BRIEF.md
# Buffered Compare-Match Interval Timer

This block is a 16-bit up-counter paired with one double-buffered compare value. Software reaches it through a small word-wide register port. A compare write lands in a front (master) copy at once. A fixed number of clocks later it moves into a back (slave) copy, and only the back copy is compared against the running count.

When the count equals the back copy while the timer runs, the block raises a one-clock interrupt request and restarts the count from zero. The result is a periodic tick whose period is the compare value plus one counted clock. An external count-enable strobe gates each increment, which lets a prescaler sit outside the block. Clearing the run bit stops the timer and zeroes the count.

Only one compare update may reach the back copy per counter period. A further update is parked in the front copy until the next match. A rewrite that arrives while a transfer is still in flight is dropped and recorded in a sticky error bit.

Top module: `cmpbuf_timer`

## Requirements
- R1: The counter resets to 0000h and increases by one (wrapping FFFFh to 0000h) on each clock where the run bit and `cnt_tick` are both high and there is no match. Otherwise it holds. It reads back at address 3, and writes to address 3 are ignored.
- R2: `irq` is high for exactly the cycles where the run bit is 1 and the count equals the back compare value. The counter is 0000h in the cycle after such a cycle.
- R3: Writing 0 to bit 0 of address 0 (run bit) forces `irq` low from the next cycle on. The counter reads 0000h one clock later and stays there while stopped.
- R4: A write to address 1 loads the front compare copy. A read of address 1 returns the front copy from the next cycle on, even while the comparison still uses the old value.
- R5: An accepted compare write at clock edge E0 reaches the back copy at edge E4. Matching against the new value is possible from the cycle after E4 and never earlier.
- R6: A compare write that arrives at edge E1, E2 or E3 after an accepted write at E0 is ignored (the front copy is unchanged). It sets status bit 0 at address 2, which stays 1 until reset.
- R7: If a transfer completes while the timer runs and an update has already reached the back copy in the current counter period, the back copy is kept. Status bit 1 at address 2 reads 1 until the next match (or until the run bit is cleared). At that point the front copy moves to the back and bit 1 returns to 0.
- R8: When a new back value below the current count takes effect, no match occurs until the counter passes FFFFh, wraps to 0000h and reaches the new value.
- R9: After reset, addresses 0 to 3 all read 0000h and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 compare, 2 status, 3 counter |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| cnt_tick | input | 1 | Count-enable strobe |
| irq | output | 1 | Compare-match interrupt request, one-clock pulse |

## Verification
The bound checker watches the counter on every cycle. It confirms the counter steps by exactly one under the strobe, holds without it, drops to zero after each match and while stopped, and that `irq` never fires while stopped. It also confirms that an accepted compare write lands in the front copy, that a write made during a transfer leaves it untouched, and that the error bit never falls.

The four-clock transfer latency, the parking of a second update until the next match, and the long wraparound before a low compare value fires all depend on history spanning many cycles. Only the bench scenarios, checked against a behavioural model on every clock, can show them.

// File: rtl/cmpbuf_pkg.sv
// Shared definitions for the buffered compare-match timer.
// Assumes a 2-bit word address on the register port.
package cmpbuf_pkg;
    localparam int unsigned REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL = 2'd0,
        RA_CMP  = 2'd1,
        RA_STAT = 2'd2,
        RA_CNT  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/cmpbuf_regs.sv
// Register front end: holds the run bit, decodes compare writes and
// multiplexes readback. Assumes single-cycle writes and a combinational read.
module cmpbuf_regs
    import cmpbuf_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic              run_wbit,
    input  logic [CW-1:0]     master,
    input  logic              err,
    input  logic              held,
    input  logic [CW-1:0]     cnt,
    output logic              run_en,
    output logic              wr_cmp,
    output logic [CW-1:0]     rdata
);
    reg_addr_e ra;
    assign ra     = reg_addr_e'(addr);
    assign wr_cmp = we && (ra == RA_CMP);

    // Run bit: written through the control word, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_en <= 1'b0;
        else if (we && ra == RA_CTRL)
            run_en <= run_wbit;
    end

    // Readback multiplexer.
    always_comb begin
        case (ra)
            RA_CTRL: rdata = {{(CW-1){1'b0}}, run_en};
            RA_CMP:  rdata = master;
            RA_STAT: rdata = {{(CW-2){1'b0}}, held, err};
            default: rdata = cnt;
        endcase
    end
endmodule

// File: rtl/cmpbuf_buffer.sv
// Master/slave compare buffer. A write loads the master. After XFER_CLKS
// edges the master moves to the slave, unless an update already landed in
// this counter period; then it waits for the next match. Writes during a
// transfer are dropped and flagged. Assumes XFER_CLKS >= 1.
module cmpbuf_buffer #(
    parameter int unsigned CW        = 16,
    parameter int unsigned XFER_CLKS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cmp,
    input  logic [CW-1:0] wdata,
    input  logic          run_en,
    input  logic          match,
    output logic [CW-1:0] master_q,
    output logic [CW-1:0] slave_q,
    output logic          busy,
    output logic          err_q,
    output logic          held_q
);
    localparam int unsigned XW = $clog2(XFER_CLKS + 1);

    logic [XW-1:0] xleft_q;
    logic          used_q;
    logic          accept, xfer_done, commit_now, hold_now, apply_held;

    assign busy       = xleft_q > XW'(1);
    assign accept     = wr_cmp && !busy;
    assign xfer_done  = xleft_q == XW'(1);
    assign commit_now = xfer_done && (!used_q || match || !run_en);
    assign hold_now   = xfer_done && !commit_now;
    assign apply_held = held_q && (match || !run_en);

    // Transfer countdown: restarted by each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            xleft_q <= '0;
        else if (accept)
            xleft_q <= XW'(XFER_CLKS);
        else if (xleft_q != '0)
            xleft_q <= xleft_q - XW'(1);
    end

    // Master copy: takes every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            master_q <= '0;
        else if (accept)
            master_q <= wdata;
    end

    // Slave copy: takes the master on a completed or released transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slave_q <= '0;
        else if (commit_now || apply_held)
            slave_q <= master_q;
    end

    // Per-period update slot and parked-update flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= 1'b0;
            held_q <= 1'b0;
        end else begin
            if (!run_en)         used_q <= 1'b0;
            else if (commit_now) used_q <= 1'b1;
            else if (match)      used_q <= 1'b0;
            if (hold_now)        held_q <= 1'b1;
            else if (apply_held) held_q <= 1'b0;
        end
    end

    // Sticky error: a compare write arrived while a transfer was in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (wr_cmp && busy)
            err_q <= 1'b1;
    end
endmodule

// File: rtl/cmpbuf_counter.sv
// Up-counter with match-and-clear. Assumes the compare value is already
// the active (slave) copy. Stopping clears the count.
module cmpbuf_counter #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          tick,
    input  logic [CW-1:0] cmp,
    output logic [CW-1:0] cnt_q,
    output logic          match
);
    assign match = run_en && (cnt_q == cmp);

    // Count under the strobe, restart on match, hold at zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run_en) cnt_q <= '0;
        else if (match)   cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/cmpbuf_timer.sv
// Top of the buffered compare-match interval timer. Joins the register
// front end, the compare buffer and the counter. Assumes one clock domain.
module cmpbuf_timer
    import cmpbuf_pkg::*;
#(
    parameter int unsigned CW        = 16,
    parameter int unsigned XFER_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [CW-1:0]     bus_wdata,
    output logic [CW-1:0]     bus_rdata,
    input  logic              cnt_tick,
    output logic              irq
);
    logic          run_en, wr_cmp, match, xfer_busy, err_q, held_q;
    logic [CW-1:0] master_q, slave_q, cnt_q;

    cmpbuf_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .run_wbit(bus_wdata[0]), .master(master_q), .err(err_q),
        .held(held_q), .cnt(cnt_q), .run_en(run_en), .wr_cmp(wr_cmp),
        .rdata(bus_rdata)
    );

    cmpbuf_buffer #(.CW(CW), .XFER_CLKS(XFER_CLKS)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_cmp(wr_cmp), .wdata(bus_wdata),
        .run_en(run_en), .match(match), .master_q(master_q),
        .slave_q(slave_q), .busy(xfer_busy), .err_q(err_q), .held_q(held_q)
    );

    cmpbuf_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(cnt_tick),
        .cmp(slave_q), .cnt_q(cnt_q), .match(match)
    );

    assign irq = match;
endmodule

// File: rtl/cmpbuf_timer_chk.sv
// Property checker for the timer, bound to every cmpbuf_timer instance.
module cmpbuf_timer_chk #(
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_en,
    input logic          tick,
    input logic          irq,
    input logic [CW-1:0] cnt,
    input logic          wr_cmp,
    input logic          busy,
    input logic [CW-1:0] wdata,
    input logic [CW-1:0] master,
    input logic          err
);
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick && !irq) |=> (cnt == $past(cnt) + CW'(1)));
    assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !tick && !irq) |=> $stable(cnt));
    assert_clear_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> (cnt == '0));
    assert_irq_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> run_en);
    assert_stopped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (cnt == '0));
    assert_master_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmp && !busy) |=> (master == $past(wdata)));
    assert_busy_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmp && busy) |=> $stable(master));
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

bind cmpbuf_timer cmpbuf_timer_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(cnt_tick), .irq(irq),
    .cnt(cnt_q), .wr_cmp(wr_cmp), .busy(xfer_busy), .wdata(bus_wdata),
    .master(master_q), .err(err_q)
);

// File: tb/cmpbuf_timer_test.sv
module cmpbuf_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        cnt_tick = 1'b0;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    // Behavioural reference state.
    bit m_en = 0, m_used = 0, m_held = 0, m_err = 0;
    int m_cnt = 0, m_master = 0, m_slave = 0, m_xleft = 0;

    cmpbuf_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_tick(cnt_tick),
        .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic report(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Reference model advanced on each rising edge.
    always @(posedge clk) begin
        bit mt, done, acc, commit, apply, cmpw;
        cyc++;
        if (!rst_n) begin
            m_en = 0; m_used = 0; m_held = 0; m_err = 0;
            m_cnt = 0; m_master = 0; m_slave = 0; m_xleft = 0;
        end else begin
            mt     = m_en && (m_cnt == m_slave);
            cmpw   = bus_we && bus_addr == 2'd1;
            done   = (m_xleft == 1);
            acc    = cmpw && (m_xleft <= 1);
            commit = done && (!m_used || mt || !m_en);
            apply  = m_held && (mt || !m_en);
            if (commit || apply) m_slave = m_master;
            if (done && !commit) m_held = 1;
            else if (apply) m_held = 0;
            if (!m_en) m_used = 0;
            else if (commit) m_used = 1;
            else if (mt) m_used = 0;
            if (cmpw && !acc) m_err = 1;
            if (acc) begin m_master = bus_wdata; m_xleft = 4; end
            else if (m_xleft > 0) m_xleft--;
            if (!m_en || mt) m_cnt = 0;
            else if (cnt_tick) m_cnt = (m_cnt + 1) % 65536;
            if (bus_we && bus_addr == 2'd0) m_en = bus_wdata[0];
        end
    end

    // Per-cycle comparison of irq and readback, away from the edge.
    always @(negedge clk) begin
        int exp_rd;
        if (rst_n) begin
            report("R2 irq", irq, (m_en && m_cnt == m_slave) ? 1 : 0);
            case (bus_addr)
                2'd0: exp_rd = m_en;
                2'd1: exp_rd = m_master;
                2'd2: exp_rd = m_held * 2 + m_err;
                default: exp_rd = m_cnt;
            endcase
            case (bus_addr)
                2'd0: report("R3 ctrl readback", bus_rdata, exp_rd);
                2'd1: report("R4 compare readback", bus_rdata, exp_rd);
                2'd2: report("R7 status readback", bus_rdata, exp_rd);
                default: report("R1 counter readback", bus_rdata, exp_rd);
            endcase
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 190000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        step();
        bus_we = 1'b0;
    endtask

    task automatic chk_reg(input logic [1:0] a, input int exp, input string tag);
        bus_addr = a;
        @(negedge clk);
        report(tag, bus_rdata, exp);
        step();
    endtask

    task automatic wait_irq(input int maxc, output int n, output bit saw_top);
        n = 0; saw_top = 0;
        forever begin
            @(negedge clk);
            if (bus_rdata == 16'hFFFF) saw_top = 1;
            if (irq || n >= maxc) break;
            n++;
        end
    endtask

    initial begin
        int n;
        bit top;
        repeat (3) step();
        rst_n = 1'b1;
        // R9: reset values
        chk_reg(2'd0, 0, "R9 ctrl");
        chk_reg(2'd1, 0, "R9 compare");
        chk_reg(2'd2, 0, "R9 status");
        chk_reg(2'd3, 0, "R9 counter");

        // R1: start with a distant compare, then stop the strobe at 3
        bus_write(2'd1, 16'd100);
        repeat (5) step();
        cnt_tick = 1'b1;
        bus_write(2'd0, 16'd1);
        repeat (3) step();
        cnt_tick = 1'b0;
        chk_reg(2'd3, 3, "R1 count under strobe");
        chk_reg(2'd3, 3, "R1 hold without strobe");

        // R4/R5: write 3 equal to the frozen count; match on the 4th edge
        bus_write(2'd1, 16'd3);
        @(negedge clk);
        report("R4 master visible next cycle", bus_rdata, 3);
        report("R5 no match before transfer", irq, 0);
        for (int k = 1; k <= 4; k++) begin
            step();
            @(negedge clk);
            report("R5 transfer latency", irq, (k == 4) ? 1 : 0);
        end
        step();
        chk_reg(2'd3, 0, "R2 cleared after match");

        // R6: rewrite two edges after an accepted write is dropped
        bus_write(2'd1, 16'd7);
        step();
        bus_write(2'd1, 16'd9);
        chk_reg(2'd1, 7, "R6 dropped write keeps master");
        chk_reg(2'd2, 1, "R6 error bit set");
        repeat (3) step();
        chk_reg(2'd2, 1, "R6 error bit sticky");

        // R2: period with compare 7 under a steady strobe is 8 cycles
        cnt_tick = 1'b1;
        bus_addr = 2'd3;
        wait_irq(100, n, top);
        step();
        wait_irq(100, n, top);
        report("R2 match period", n + 1, 8);
        step();

        // R7: second update in one period is parked until the match
        bus_write(2'd0, 16'd0);
        bus_write(2'd1, 16'd50);
        repeat (5) step();
        bus_write(2'd0, 16'd1);
        repeat (5) step();
        bus_write(2'd1, 16'd40);
        repeat (6) step();
        bus_write(2'd1, 16'd20);
        repeat (6) step();
        chk_reg(2'd2, 3, "R7 held flag raised");
        bus_addr = 2'd3;
        wait_irq(200, n, top);
        report("R7 first match uses committed value", bus_rdata, 40);
        step();
        chk_reg(2'd2, 1, "R7 held flag released at match");
        bus_addr = 2'd3;
        wait_irq(200, n, top);
        report("R7 next period uses parked value", bus_rdata, 20);
        step();

        // R1: irregular strobe and an ignored counter write
        bus_write(2'd3, 16'h1234);
        for (int k = 0; k < 300; k++) begin
            cnt_tick = ((k * 7) % 5) < 3;
            step();
        end
        bus_addr = 2'd3;
        @(negedge clk);
        report("R1 counter write ignored", bus_rdata, m_cnt);
        step();

        // R8: compare below the count fires only after wraparound
        cnt_tick = 1'b1;
        bus_write(2'd0, 16'd0);
        bus_write(2'd1, 16'd3000);
        repeat (5) step();
        bus_write(2'd0, 16'd1);
        repeat (2500) step();
        bus_write(2'd1, 16'd100);
        bus_addr = 2'd3;
        wait_irq(70000, n, top);
        report("R8 match value after wrap", bus_rdata, 100);
        report("R8 counter passed FFFFh", top, 1);
        report("R8 long wait before match", (n > 60000) ? 1 : 0, 1);
        step();

        // R3: stopping clears the count and silences irq
        repeat (10) step();
        bus_write(2'd0, 16'd0);
        @(negedge clk);
        report("R3 irq low when stopped", irq, 0);
        step();
        chk_reg(2'd3, 0, "R3 counter cleared");
        chk_reg(2'd3, 0, "R3 counter stays zero");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule